// File: doc/BRIEF.md
# Bus-Master DMA Register Window

This block is the host-visible register window of a two-channel bus-master disk DMA controller. It occupies sixteen byte ports. Bit 3 of the port offset picks the channel, and the low three bits pick a register inside that channel. Each channel holds a command byte, a status byte and a 32-bit pointer to a descriptor table. The host reaches them with byte-granular reads and writes of one to four bytes.

The window passes start and rewind pulses, plus the transfer direction, to a separate DMA engine. The engine reports completion and faults back, and those reports land in the status byte. Accesses with an illegal offset or length are refused. A refused access changes no state, and a refused read returns all ones. Read data is combinational from the stored registers. Writes take effect at the clock edge that samples them.

Top module: `bmdma_regs`

## Requirements
- R1: Offset bit 3 selects channel 0 or 1. Within a channel, offset 0 is command, offset 2 is status, and offsets 4 to 7 are pointer bytes 0 to 3 (least significant first). A read returns the addressed bytes in data lanes 0 upward, with unused lanes zero.
- R2: A command write keeps only bits 0 (start) and 3 (direction) of the written byte. A command read returns that masked value.
- R3: A command write with bit 0 set sets status bit 0 (active). In the cycle after the write, it raises that channel's go output for exactly one cycle. The direction output always equals stored command bit 3.
- R4: A command write with bit 0 clear raises that channel's rewind output for one cycle after the write and leaves status bit 0 as it was.
- R5: A status write loads bits 6:5 from the data, preserves bit 0, clears each of bits 2:1 whose written bit is 1, and leaves bits 7, 4 and 3 reading zero.
- R6: Pointer bytes are individually writable at any start offset 4 to 7 for any length that fits. A read returns the bytes as last written.
- R7: A pointer access whose start byte index plus length exceeds 4 is refused, and the pointer is left unchanged.
- R8: An access with offset 1 or 3, length 0 or above 4, or a command or status access of length other than 1 raises the reject output, reads back as 0xFFFFFFFF and changes no register.
- R9: The engine done input clears active and sets status bit 2 (interrupt). The engine fault input sets status bit 1 (error). These sets win over a same-cycle host clear, and a same-cycle start keeps active set.
- R10: After reset, all registers read zero, and the go, rewind and direction outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host access strobe |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_off | input | 4 | Port offset within the window |
| host_len | input | 3 | Access length in bytes |
| host_wdata | input | 32 | Write data, byte 0 in lane 0 |
| host_rdata | output | 32 | Read data (combinational) |
| host_reject | output | 1 | Access refused |
| eng_done | input | 2 | Per-channel transfer completion |
| eng_fault | input | 2 | Per-channel transfer fault |
| eng_go | output | 2 | Per-channel start pulse |
| eng_rewind | output | 2 | Per-channel descriptor-index rewind pulse |
| eng_dir_rd | output | 2 | Per-channel transfer direction |

## Verification
Every stored byte is visible on a read in the same cycle, so a wrong merge, mask or lane placement appears on the very next read of that offset. A misrouted channel bit corrupts the other channel's readback. A wrong pulse decode shows on go or rewind one cycle after the command write. A lost priority between engine events and host writes shows on the status read that follows the colliding cycle. The bench writes every offset and length pairing and then reads back the whole window, so a corrupted register is caught within one write.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  localparam int BYTE_W    = 8;
  localparam int PTR_BYTES = 4;
  localparam int PTR_W     = BYTE_W * PTR_BYTES;
  localparam int LEN_W     = 3;
  localparam int IDX_W     = $clog2(PTR_BYTES);

  localparam logic [BYTE_W-1:0] CMD_KEEP   = 8'h09;
  localparam logic [BYTE_W-1:0] ST_PLAIN   = 8'h60;
  localparam logic [BYTE_W-1:0] ST_HOLD    = 8'h01;
  localparam logic [BYTE_W-1:0] ST_W1C     = 8'h06;

  typedef enum logic [1:0] {RK_CMD, RK_STAT, RK_PTR, RK_BAD} reg_kind_t;

  function automatic logic [BYTE_W-1:0] cmd_keep(input logic [BYTE_W-1:0] d);
    return d & CMD_KEEP;
  endfunction

  function automatic logic [BYTE_W-1:0] stat_merge(input logic [BYTE_W-1:0] old_v,
                                                   input logic [BYTE_W-1:0] d);
    return (d & ST_PLAIN) | (old_v & ST_HOLD) | (old_v & ~d & ST_W1C);
  endfunction

  function automatic logic window_fits(input logic [IDX_W-1:0] idx,
                                       input logic [LEN_W-1:0] len);
    logic [LEN_W:0] sum;
    sum = {{(LEN_W+1-IDX_W){1'b0}}, idx} + {1'b0, len};
    return (len != '0) && (sum <= PTR_BYTES[LEN_W:0]);
  endfunction

  function automatic logic [PTR_W-1:0] lane_mask(input logic [LEN_W-1:0] len);
    logic [PTR_W-1:0] m;
    m = '0;
    for (int b = 0; b < PTR_BYTES; b++)
      if (b < int'(len)) m[b*BYTE_W +: BYTE_W] = '1;
    return m;
  endfunction
endpackage

// File: rtl/bmdma_decode.sv
module bmdma_decode
  import bmdma_pkg::*;
(
  input  logic [3:0]       off,
  input  logic [LEN_W-1:0] len,
  output reg_kind_t        kind,
  output logic             chan,
  output logic [IDX_W-1:0] idx,
  output logic             ok
);
  logic [2:0] reg_sel;
  assign reg_sel = off[2:0];
  assign chan    = off[3];
  assign idx     = reg_sel[IDX_W-1:0];

  always_comb begin
    kind = RK_BAD;
    ok   = 1'b0;
    if (reg_sel[2]) begin
      kind = RK_PTR;
      ok   = window_fits(idx, len);
    end else if (reg_sel == 3'd0) begin
      kind = RK_CMD;
      ok   = (len == LEN_W'(1));
    end else if (reg_sel == 3'd2) begin
      kind = RK_STAT;
      ok   = (len == LEN_W'(1));
    end
  end
endmodule

// File: rtl/bmdma_chan.sv
module bmdma_chan
  import bmdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic              st_we,
  input  logic              ptr_we,
  input  logic [IDX_W-1:0]  idx,
  input  logic [LEN_W-1:0]  len,
  input  logic [PTR_W-1:0]  wdata,
  input  logic              done,
  input  logic              fault,
  output logic [BYTE_W-1:0] cmd_q,
  output logic [BYTE_W-1:0] st_q,
  output logic [PTR_W-1:0]  ptr_q,
  output logic              go,
  output logic              rewind
);
  logic              start_evt;
  logic              stop_evt;
  logic [BYTE_W-1:0] st_next;
  logic [PTR_W-1:0]  wr_shift;
  logic [PTR_W-1:0]  wr_mask;

  assign start_evt = cmd_we &  wdata[0];
  assign stop_evt  = cmd_we & ~wdata[0];
  assign wr_shift  = wdata << (BYTE_W * idx);
  assign wr_mask   = lane_mask(len) << (BYTE_W * idx);

  always_comb begin
    st_next = st_q;
    if (st_we) st_next = stat_merge(st_q, wdata[BYTE_W-1:0]);
    if (done) begin
      st_next[0] = 1'b0;
      st_next[2] = 1'b1;
    end
    if (fault) st_next[1] = 1'b1;
    if (start_evt) st_next[0] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      st_q   <= '0;
      go     <= 1'b0;
      rewind <= 1'b0;
    end else begin
      if (cmd_we) cmd_q <= cmd_keep(wdata[BYTE_W-1:0]);
      st_q   <= st_next;
      go     <= start_evt;
      rewind <= stop_evt;
    end
  end

  for (genvar b = 0; b < PTR_BYTES; b++) begin : g_ptr
    always_ff @(posedge clk) begin
      if (!rst_n)
        ptr_q[b*BYTE_W +: BYTE_W] <= '0;
      else if (ptr_we && wr_mask[b*BYTE_W])
        ptr_q[b*BYTE_W +: BYTE_W] <= wr_shift[b*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs
  import bmdma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_wr,
  input  logic [3:0]        host_off,
  input  logic [LEN_W-1:0]  host_len,
  input  logic [PTR_W-1:0]  host_wdata,
  output logic [PTR_W-1:0]  host_rdata,
  output logic              host_reject,
  input  logic [1:0]        eng_done,
  input  logic [1:0]        eng_fault,
  output logic [1:0]        eng_go,
  output logic [1:0]        eng_rewind,
  output logic [1:0]        eng_dir_rd
);
  localparam int NCH = 2;

  reg_kind_t        dec_kind;
  logic             dec_ch;
  logic [IDX_W-1:0] dec_idx;
  logic             dec_ok;
  logic             wr_ok;

  logic [NCH-1:0][BYTE_W-1:0] cmd_arr;
  logic [NCH-1:0][BYTE_W-1:0] st_arr;
  logic [NCH-1:0][PTR_W-1:0]  ptr_arr;

  bmdma_decode u_dec (
    .off  (host_off),
    .len  (host_len),
    .kind (dec_kind),
    .chan (dec_ch),
    .idx  (dec_idx),
    .ok   (dec_ok)
  );

  assign wr_ok       = host_req & host_wr & dec_ok;
  assign host_reject = host_req & ~dec_ok;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit;
    assign hit = wr_ok & (dec_ch == c[0]);
    bmdma_chan u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .cmd_we (hit & (dec_kind == RK_CMD)),
      .st_we  (hit & (dec_kind == RK_STAT)),
      .ptr_we (hit & (dec_kind == RK_PTR)),
      .idx    (dec_idx),
      .len    (host_len),
      .wdata  (host_wdata),
      .done   (eng_done[c]),
      .fault  (eng_fault[c]),
      .cmd_q  (cmd_arr[c]),
      .st_q   (st_arr[c]),
      .ptr_q  (ptr_arr[c]),
      .go     (eng_go[c]),
      .rewind (eng_rewind[c])
    );
    assign eng_dir_rd[c] = cmd_arr[c][3];
  end

  always_comb begin
    host_rdata = '0;
    if (host_req && !host_wr) begin
      if (!dec_ok) host_rdata = '1;
      else begin
        unique case (dec_kind)
          RK_CMD:  host_rdata = PTR_W'(cmd_arr[dec_ch]);
          RK_STAT: host_rdata = PTR_W'(st_arr[dec_ch]);
          RK_PTR:  host_rdata = (ptr_arr[dec_ch] >> (BYTE_W * dec_idx)) & lane_mask(host_len);
          default: host_rdata = '1;
        endcase
      end
    end
  end
endmodule

// File: rtl/bmdma_chk.sv
module bmdma_chk
  import bmdma_pkg::*;
(
  input logic                       clk,
  input logic                       rst_n,
  input logic                       host_req,
  input logic                       host_wr,
  input logic [3:0]                 host_off,
  input logic [LEN_W-1:0]           host_len,
  input logic [PTR_W-1:0]           host_wdata,
  input logic [PTR_W-1:0]           host_rdata,
  input logic                       host_reject,
  input logic [1:0]                 eng_done,
  input logic [1:0]                 eng_fault,
  input logic [1:0]                 eng_go,
  input logic [1:0]                 eng_rewind,
  input logic [1:0][BYTE_W-1:0]     cmd_arr,
  input logic [1:0][BYTE_W-1:0]     st_arr,
  input logic [1:0][PTR_W-1:0]      ptr_arr
);
  logic start0, stop1;
  assign start0 = host_req && host_wr && host_off == 4'h0 && host_len == 3'd1 && host_wdata[0];
  assign stop1  = host_req && host_wr && host_off == 4'h8 && host_len == 3'd1 && !host_wdata[0];

  p_cmd_read_masked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !host_wr && host_off == 4'h0 && host_len == 3'd1) |-> ((host_rdata & 32'hFFFF_FFF6) == 0));

  p_go_follows_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_go[0] |-> $past(start0));

  p_active_rise_with_go_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_arr[0][0]) |-> eng_go[0]);

  p_rewind_follows_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    eng_rewind[1] |-> $past(stop1));

  p_reject_reads_ones_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !host_wr && host_reject) |-> host_rdata == 32'hFFFF_FFFF);

  p_reject_keeps_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && host_wr && host_reject && eng_done == 2'b00 && eng_fault == 2'b00)
      |=> ($stable(ptr_arr) && $stable(cmd_arr) && $stable(st_arr)));

  p_done_clears_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done[0] && !start0) |=> (!st_arr[0][0] && st_arr[0][2]));

  p_fault_sets_error_r9: assert property (@(posedge clk) disable iff (!rst_n)
    eng_fault[1] |=> st_arr[1][1]);
endmodule

bind bmdma_regs bmdma_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_req   (host_req),
  .host_wr    (host_wr),
  .host_off   (host_off),
  .host_len   (host_len),
  .host_wdata (host_wdata),
  .host_rdata (host_rdata),
  .host_reject(host_reject),
  .eng_done   (eng_done),
  .eng_fault  (eng_fault),
  .eng_go     (eng_go),
  .eng_rewind (eng_rewind),
  .cmd_arr    (cmd_arr),
  .st_arr     (st_arr),
  .ptr_arr    (ptr_arr)
);

// File: tb/bmdma_regs_bench.sv
module bmdma_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 1'b0;
  logic        host_wr = 1'b0;
  logic [3:0]  host_off = '0;
  logic [2:0]  host_len = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        host_reject;
  logic [1:0]  eng_done = '0;
  logic [1:0]  eng_fault = '0;
  logic [1:0]  eng_go, eng_rewind, eng_dir_rd;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  logic [7:0]  m_cmd [2];
  logic [7:0]  m_st  [2];
  logic [31:0] m_ptr [2];

  always #4 clk = ~clk;

  bmdma_regs u_bmdma_regs (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
    .host_off(host_off), .host_len(host_len), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_reject(host_reject),
    .eng_done(eng_done), .eng_fault(eng_fault), .eng_go(eng_go),
    .eng_rewind(eng_rewind), .eng_dir_rd(eng_dir_rd)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit b_ok(input int off, input int len);
    int r = off % 8;
    if (len < 1 || len > 4) return 0;
    if (r == 0 || r == 2) return len == 1;
    if (r >= 4) return (r - 4) + len <= 4;
    return 0;
  endfunction

  function automatic logic [31:0] b_read(input int off, input int len);
    int ch = off / 8;
    int r = off % 8;
    logic [63:0] v;
    if (!b_ok(off, len)) return 32'hFFFF_FFFF;
    if (r == 0) return {24'd0, m_cmd[ch]};
    if (r == 2) return {24'd0, m_st[ch]};
    v = {32'd0, m_ptr[ch]} >> (8 * (r - 4));
    v = v & ((64'd1 << (8 * len)) - 64'd1);
    return v[31:0];
  endfunction

  task automatic wr(input int off, input int len, input logic [31:0] d);
    int ch = off / 8;
    int r = off % 8;
    bit ok = b_ok(off, len);
    logic [1:0] exp_go = '0;
    logic [1:0] exp_rw = '0;
    host_req = 1; host_wr = 1; host_off = off[3:0]; host_len = len[2:0]; host_wdata = d;
    #1;
    chk(ok ? "R1 reject low" : "R8 reject high", {31'd0, host_reject}, {31'd0, !ok});
    if (ok) begin
      if (r == 0) begin
        m_cmd[ch] = d[7:0] & 8'h09;
        if (d[0]) begin m_st[ch][0] = 1'b1; exp_go[ch] = 1'b1; end
        else exp_rw[ch] = 1'b1;
      end else if (r == 2) begin
        m_st[ch] = (d[7:0] & 8'h60) | (m_st[ch] & 8'h01) | (m_st[ch] & ~d[7:0] & 8'h06);
      end else begin
        for (int k = 0; k < len; k++) m_ptr[ch][8*(r-4+k) +: 8] = d[8*k +: 8];
      end
    end
    for (int c = 0; c < 2; c++) begin
      if (eng_done[c]) begin m_st[c][0] = 1'b0; m_st[c][2] = 1'b1; end
      if (eng_fault[c]) m_st[c][1] = 1'b1;
      if (exp_go[c]) m_st[c][0] = 1'b1;
    end
    @(posedge clk); @(negedge clk);
    host_req = 0; host_wr = 0; eng_done = '0; eng_fault = '0;
    chk("R3 go pulse", {30'd0, eng_go}, {30'd0, exp_go});
    chk("R4 rewind pulse", {30'd0, eng_rewind}, {30'd0, exp_rw});
    chk("R3 direction", {30'd0, eng_dir_rd}, {30'd0, m_cmd[1][3], m_cmd[0][3]});
  endtask

  task automatic rd(input string tag, input int off, input int len);
    host_req = 1; host_wr = 0; host_off = off[3:0]; host_len = len[2:0];
    #2;
    chk(tag, host_rdata, b_read(off, len));
    @(negedge clk);
    host_req = 0;
  endtask

  task automatic rd_all(input string tag);
    for (int o = 0; o < 16; o++)
      for (int l = 1; l <= 4; l++) rd(tag, o, l);
  endtask

  initial begin
    for (int c = 0; c < 2; c++) begin m_cmd[c] = 0; m_st[c] = 0; m_ptr[c] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R10 outputs after reset", {26'd0, eng_go, eng_rewind, eng_dir_rd}, 32'd0);
    rd_all("R10 reset readback");
    rd("R8 zero length read", 4, 0);
    rd("R8 length five read", 0, 5);
    rd("R8 offset 3 read", 3, 1);

    for (int o = 0; o < 16; o++)
      for (int l = 0; l <= 5; l++) begin
        logic [7:0] x;
        x = 8'(o * 29 + l * 53 + 17);
        wr(o, l, {x + 8'd3, x + 8'd2, x + 8'd1, x});
        rd_all((o % 8 == 2) ? "R5 status sweep" : (o % 8 >= 4) ? "R6 R7 pointer sweep" : "R2 R1 sweep");
      end

    wr(8, 1, 32'h01);
    rd("R3 active set ch1", 10, 1);
    eng_done = 2'b10; eng_fault = 2'b10;
    wr(3, 1, 32'h0);
    rd("R9 done clears active, sets irq and error", 10, 1);
    wr(10, 1, 32'h06);
    rd("R5 w1c clears bits 2:1", 10, 1);
    eng_fault = 2'b10;
    wr(10, 1, 32'h02);
    rd("R9 fault beats host clear", 10, 1);
    eng_done = 2'b01;
    wr(0, 1, 32'h09);
    rd("R9 start beats done", 2, 1);
    wr(0, 1, 32'h08);
    rd("R4 stop keeps active", 2, 1);
    wr(7, 2, 32'hDEAD);
    rd_all("R7 overrun leaves pointer");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R10 actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule